// File: doc/BRIEF.md
# DRAM Bank Open-Row Tracker

This block sits in the front end of a memory controller and keeps track of which row is held open in each bank of a DDR4-style device. Sixteen banks are organised as four bank groups of four banks each. A bank either is idle or has exactly one active row, and every bank is tracked independently. The scheduler issues command strobes (activate, read, write, precharge of one bank, precharge of all banks), and the tracker updates its per-bank state on the next clock edge.

On a separate query path, the scheduler presents a candidate request address: bank group, bank and row. The tracker reports in the same cycle whether that request is a page hit, a page miss or a page empty, and which command the scheduler needs to issue next. With this information the scheduler can favour requests that target rows already open. The query is a pure lookup of the current state. It has no handshake and never stalls, so there is no back-pressure on either path: a command is taken on every cycle in which its strobe is high.

A command that breaks the protocol sets a sticky error flag and leaves the bank state unchanged. Such commands are a read or write to an idle bank, or an activate to a bank that already has a row open.

Top module: `bank_row_tracker`

## Requirements
- R1: The bank index is {bank_group, bank}, so group 3 bank 3 is bank 15. Each of the 16 banks holds its own state, and a command to one bank leaves every other bank unchanged.
- R2: A synchronous active-high reset makes every bank idle and clears the error flag.
- R3: A valid activate (op 3'd0) to an idle bank opens that bank with the given row from the next cycle on.
- R4: The query class is 2'b00 (empty) when the addressed bank is idle. It is 2'b01 (hit) when the bank is open on the queried row, and 2'b10 (miss) when the bank is open on another row. It is derived combinationally from the current state.
- R5: The next-command output is 2'b00 (activate) for empty, 2'b01 (read/write) for hit and 2'b10 (precharge) for miss.
- R6: A read (op 3'd1) or write (op 3'd2) to an open bank leaves all bank state unchanged.
- R7: A precharge (op 3'd3) closes only the addressed bank. A precharge to an idle bank is legal and has no effect.
- R8: A precharge-all (op 3'd4) closes every bank in a single cycle and never raises the error flag.
- R9: A read or write to an idle bank, or an activate to an open bank, raises the error flag in the next cycle and leaves all bank state unchanged.
- R10: The error flag stays set until reset, whatever commands follow.
- R11: A command with the strobe low, or one with an unused opcode (3'd5 to 3'd7), has no effect on state or on the error flag.
- R12: Bit i of the open-bank mask output is 1 exactly when bank i has an open row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command issued this cycle |
| cmd_op | input | 3 | Command opcode: 0 activate, 1 read, 2 write, 3 precharge, 4 precharge-all |
| cmd_bg | input | 2 | Command bank group |
| cmd_ba | input | 2 | Command bank within group |
| cmd_row | input | 16 | Row for activate |
| req_bg | input | 2 | Query bank group |
| req_ba | input | 2 | Query bank within group |
| req_row | input | 16 | Query row |
| req_class | output | 2 | Page class of query: 00 empty, 01 hit, 10 miss |
| req_next | output | 2 | Command needed next: 00 activate, 01 read/write, 10 precharge |
| open_mask | output | 16 | One bit per bank, set while the bank has an open row |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The query outputs are combinational, so they are due in the same cycle that the query address and the current state are present. A command changes the bank state and the error flag one clock edge after its strobe. The bench drives each command while the clock is low and lets it be taken at the next rising edge. It then drops the strobe, applies the query, and samples shortly after that edge. This means every comparison sees the state exactly one edge after its command, with no command pending.

// File: rtl/brt_pkg.sv
package brt_pkg;

  typedef enum logic [2:0] {
    OP_ACT  = 3'd0,
    OP_RD   = 3'd1,
    OP_WR   = 3'd2,
    OP_PRE  = 3'd3,
    OP_PREA = 3'd4
  } brt_op_e;

  typedef enum logic [1:0] {
    PG_EMPTY = 2'b00,
    PG_HIT   = 2'b01,
    PG_MISS  = 2'b10
  } brt_class_e;

  typedef enum logic [1:0] {
    NX_ACT = 2'b00,
    NX_COL = 2'b01,
    NX_PRE = 2'b10
  } brt_next_e;

endpackage

// File: rtl/brt_bank_slot.sv
module brt_bank_slot #(
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_en,
  input  logic             close_en,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open <= 1'b0;
      row_q   <= '0;
    end else if (close_en) begin
      is_open <= 1'b0;
    end else if (open_en) begin
      is_open <= 1'b1;
      row_q   <= row_in;
    end
  end

  // R1
  slot_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({open_en, close_en}));

  // R3
  slot_open_chk: assert property (@(posedge clk) disable iff (rst)
    open_en |=> (is_open && row_q == $past(row_in)));

  // R7
  slot_close_chk: assert property (@(posedge clk) disable iff (rst)
    close_en |=> !is_open);

endmodule

// File: rtl/brt_cmd_decode.sv
module brt_cmd_decode
  import brt_pkg::*;
#(
  parameter int BANK_W = 4,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [NBANK-1:0]  open_mask,
  output logic [NBANK-1:0]  open_vec,
  output logic [NBANK-1:0]  close_vec,
  output logic              err_q
);

  logic is_act, is_col, is_pre, is_prea, tgt_open, err_set;

  always_comb begin
    is_act   = cmd_valid && (cmd_op == OP_ACT);
    is_col   = cmd_valid && ((cmd_op == OP_RD) || (cmd_op == OP_WR));
    is_pre   = cmd_valid && (cmd_op == OP_PRE);
    is_prea  = cmd_valid && (cmd_op == OP_PREA);
    tgt_open = open_mask[cmd_bank];
    err_set  = (is_col && !tgt_open) || (is_act && tgt_open);
  end

  for (genvar i = 0; i < NBANK; i++) begin : g_vec
    assign open_vec[i]  = is_act && !tgt_open && (cmd_bank == BANK_W'(i));
    assign close_vec[i] = is_prea || (is_pre && (cmd_bank == BANK_W'(i)));
  end

  always_ff @(posedge clk) begin
    if (rst)          err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  // R9
  err_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (is_col && !open_mask[cmd_bank]) |=> err_q);

  // R8
  prea_noerr_chk: assert property (@(posedge clk) disable iff (rst)
    (is_prea && !err_q) |=> !err_q);

endmodule

// File: rtl/brt_req_classify.sv
module brt_req_classify
  import brt_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int ROW_W  = 16,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic [BANK_W-1:0]           req_bank,
  input  logic [ROW_W-1:0]            req_row,
  input  logic [NBANK-1:0]            open_mask,
  input  logic [NBANK-1:0][ROW_W-1:0] rows,
  output logic [1:0]                  cls,
  output logic [1:0]                  nxt
);

  brt_class_e c;

  always_comb begin
    if (!open_mask[req_bank])             c = PG_EMPTY;
    else if (rows[req_bank] == req_row)   c = PG_HIT;
    else                                  c = PG_MISS;
    cls = c;
    unique case (c)
      PG_HIT:  nxt = NX_COL;
      PG_MISS: nxt = NX_PRE;
      default: nxt = NX_ACT;
    endcase
  end

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
  import brt_pkg::*;
#(
  parameter int BG_W  = 2,
  parameter int BA_W  = 2,
  parameter int ROW_W = 16,
  localparam int BANK_W = BG_W + BA_W,
  localparam int NBANK  = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BG_W-1:0]   cmd_bg,
  input  logic [BA_W-1:0]   cmd_ba,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [BG_W-1:0]   req_bg,
  input  logic [BA_W-1:0]   req_ba,
  input  logic [ROW_W-1:0]  req_row,
  output logic [1:0]        req_class,
  output logic [1:0]        req_next,
  output logic [NBANK-1:0]  open_mask,
  output logic              proto_err
);

  logic [BANK_W-1:0]           cmd_bank, req_bank;
  logic [NBANK-1:0]            open_vec, close_vec;
  logic [NBANK-1:0][ROW_W-1:0] rows;

  assign cmd_bank = {cmd_bg, cmd_ba};
  assign req_bank = {req_bg, req_ba};

  brt_cmd_decode #(.BANK_W(BANK_W)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank),
    .open_mask (open_mask),
    .open_vec  (open_vec),
    .close_vec (close_vec),
    .err_q     (proto_err)
  );

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    brt_bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .open_en  (open_vec[i]),
      .close_en (close_vec[i]),
      .row_in   (cmd_row),
      .is_open  (open_mask[i]),
      .row_q    (rows[i])
    );
  end

  brt_req_classify #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_cls (
    .req_bank  (req_bank),
    .req_row   (req_row),
    .open_mask (open_mask),
    .rows      (rows),
    .cls       (req_class),
    .nxt       (req_next)
  );

  // R8
  prea_all_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_PREA) |=> (open_mask == '0));

  // R4
  hit_open_chk: assert property (@(posedge clk) disable iff (rst)
    (req_class == PG_HIT) |-> open_mask[req_bank]);

  // R9
  act_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_ACT && open_mask[cmd_bank]) |=> $stable(open_mask));

  // R11
  idle_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid || cmd_op > 3'd4) |=> $stable(open_mask));

endmodule

// File: tb/sim_bank_row_tracker.sv
module sim_bank_row_tracker;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic        v;
    logic [2:0]  op;
    logic [3:0]  bank;
    logic [15:0] row;
    logic [3:0]  qbank;
    logic [15:0] qrow;
    logic [1:0]  cls;
  } vec_t;

  localparam int NV = 13;
  // Classes: 00 empty, 01 hit, 10 miss. Ops: 0 ACT,1 RD,2 WR,3 PRE,4 PREA.
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd0, 4'd5,  16'h1234, 4'd5,  16'h1234, 2'b01}, // R3 open bank 5
    '{1'b0, 3'd0, 4'd5,  16'h0000, 4'd5,  16'h0999, 2'b10}, // R4 miss
    '{1'b0, 3'd0, 4'd0,  16'h0000, 4'd6,  16'h1234, 2'b00}, // R1 other bank idle
    '{1'b1, 3'd0, 4'd15, 16'hBEEF, 4'd15, 16'hBEEF, 2'b01}, // R1 group 3 bank 3
    '{1'b1, 3'd1, 4'd5,  16'h0000, 4'd5,  16'h1234, 2'b01}, // R6 read
    '{1'b1, 3'd2, 4'd15, 16'h0000, 4'd15, 16'h0000, 2'b10}, // R6 write, miss
    '{1'b1, 3'd3, 4'd5,  16'h0000, 4'd5,  16'h1234, 2'b00}, // R7 precharge
    '{1'b1, 3'd3, 4'd5,  16'h0000, 4'd15, 16'hBEEF, 2'b01}, // R7 idle pre, other kept
    '{1'b1, 3'd0, 4'd0,  16'hFFFF, 4'd0,  16'hFFFF, 2'b01}, // R3 bank 0
    '{1'b1, 3'd5, 4'd0,  16'h0000, 4'd0,  16'hFFFF, 2'b01}, // R11 unused op
    '{1'b0, 3'd4, 4'd0,  16'h0000, 4'd15, 16'hBEEF, 2'b01}, // R11 strobe low
    '{1'b1, 3'd4, 4'd0,  16'h0000, 4'd0,  16'hFFFF, 2'b00}, // R8 precharge-all
    '{1'b0, 3'd0, 4'd0,  16'h0000, 4'd15, 16'hBEEF, 2'b00}  // R8 bank 15 too
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_bg = '0, cmd_ba = '0;
  logic [15:0] cmd_row = '0;
  logic [1:0]  req_bg = '0, req_ba = '0;
  logic [15:0] req_row = '0;
  logic [1:0]  req_class, req_next;
  logic [15:0] open_mask;
  logic        proto_err;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  bank_row_tracker u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bg(cmd_bg), .cmd_ba(cmd_ba), .cmd_row(cmd_row),
    .req_bg(req_bg), .req_ba(req_ba), .req_row(req_row),
    .req_class(req_class), .req_next(req_next),
    .open_mask(open_mask), .proto_err(proto_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [3:0] bank,
                      input logic [15:0] row);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_bg = bank[3:2]; cmd_ba = bank[1:0]; cmd_row = row;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  task automatic query(input logic [3:0] bank, input logic [15:0] row);
    req_bg = bank[3:2]; req_ba = bank[1:0]; req_row = row;
    #1;
  endtask

  function automatic logic [1:0] next_of(input logic [1:0] c);
    return c;  // R5: empty->00 ACT, hit->01 RD/WR, miss->10 PRE
  endfunction

  task automatic do_reset;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    query(4'd9, 16'h0);
    check("R2 mask", 32'(open_mask), 32'h0);
    check("R2 err", 32'(proto_err), 32'h0);
    check("R4 empty after reset", 32'(req_class), 32'h0);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k].v, VEC[k].op, VEC[k].bank, VEC[k].row);
      query(VEC[k].qbank, VEC[k].qrow);
      check($sformatf("R4 class vec%0d", k), 32'(req_class), 32'(VEC[k].cls));
      check($sformatf("R5 next vec%0d", k), 32'(req_next), 32'(next_of(VEC[k].cls)));
      check($sformatf("R9 no err vec%0d", k), 32'(proto_err), 32'h0);
    end
    check("R12 mask after all", 32'(open_mask), 32'h0);

    // R12 mask bits follow opens
    step(1'b1, 3'd0, 4'd2, 16'h0001);
    step(1'b1, 3'd0, 4'd9, 16'h0002);
    check("R12 mask two banks", 32'(open_mask), 32'h0204);

    // R9 read to idle bank
    step(1'b1, 3'd1, 4'd3, 16'h0);
    check("R9 err read idle", 32'(proto_err), 32'h1);
    check("R9 state kept", 32'(open_mask), 32'h0204);

    // R9 activate to open bank leaves row
    step(1'b1, 3'd0, 4'd2, 16'h0777);
    query(4'd2, 16'h0001);
    check("R9 act busy keeps row", 32'(req_class), 32'h1);

    // R10 sticky through idle cycles and PREA
    step(1'b0, 3'd0, 4'd0, 16'h0);
    step(1'b1, 3'd4, 4'd0, 16'h0);
    check("R10 sticky", 32'(proto_err), 32'h1);
    check("R8 all closed", 32'(open_mask), 32'h0);

    // R2 reset clears error
    do_reset();
    check("R2 err cleared", 32'(proto_err), 32'h0);

    // R9 act to open bank from clean state; R1 untouched neighbour
    step(1'b1, 3'd0, 4'd2, 16'h0001);
    step(1'b1, 3'd0, 4'd2, 16'h0002);
    check("R9 err act busy", 32'(proto_err), 32'h1);
    query(4'd2, 16'h0001);
    check("R9 row unchanged", 32'(req_class), 32'h1);
    check("R1 only bank 2", 32'(open_mask), 32'h0004);

    // R9 write to idle bank also checked after reset
    do_reset();
    step(1'b1, 3'd2, 4'd7, 16'h0);
    check("R9 err write idle", 32'(proto_err), 32'h1);
    check("R9 write idle no open", 32'(open_mask), 32'h0);

    finish_run();
  end

endmodule